// File: doc/BRIEF.md
# DRAM Address Multiplexer and Strobe Sequencer

This block turns one aligned 16-bit CPU access into a multiplexed DRAM cycle. It drives up to two rows of memory modules. The CPU presents word address bits 23:1, the two byte strobes, a read/write flag and an address strobe. The block then runs a fixed sequence:

1. It raises the shared row strobe.
2. It switches the 10-bit DRAM address from the row map to the column map.
3. It raises the column strobes of the selected module row.
4. It acknowledges the CPU and holds the cycle until the address strobe falls.
5. It waits through a fixed precharge before it can start another row strobe.

Two straps configure the memory. One strap gives the module size: 64K, 256K or 1M. The other says whether a second row of modules is fitted. The size picks the source of the row/column bit in slot 7, the upper address bit in slot 9, and the address bit that chooses the module row. A startup inhibit input blocks every strobe while it is active. All control signals are active high.

Top module: `dram_mux_seq`

## Requirements
- R1: After reset, `ras`, `cas_hi`, `cas_lo`, `we` and `dack` are all 0.
- R2: While `ras` is high, `dram_addr` bits 0..9 carry, in order: A1, A11, A12, A13, A14, A15, A16, X7r, A18, X9r. X7r is A10 when `mod_size`=0 (64K) and A17 otherwise. X9r is A20 when `mod_size`=2 (1M) and 0 otherwise.
- R3: In the column phase, `dram_addr` bits 0..9 carry, in order: A2, A3, A4, A5, A6, A7, A8, A9, A10, X9c. X9c is A19 for `mod_size`=2 and 0 otherwise. The column phase starts one clock after `ras` rises and lasts until the strobes release.
- R4: The column strobes rise two clocks after `ras` rises. `ras` is always high while any column strobe is high.
- R5: The module row is chosen by a size-dependent address bit: A17 for 64K, A19 for 256K and A21 for 1M. Row 0 uses bit 0 of `cas_hi` and `cas_lo`; row 1 uses bit 1.
- R6: When `two_rows` is 0, bit 1 of `cas_hi` and `cas_lo` never asserts, and every access goes to row 0.
- R7: `cas_hi` of the selected row follows `uds`, and `cas_lo` follows `lds`.
- R8: `dack` rises one clock after the column strobes. All strobes and `dack` drop on the clock after `addr_strobe` falls.
- R9: Once `ras` falls, it stays low for at least PRECHARGE_CLKS clocks (default 2). An access that is pending when that time ends starts at once.
- R10: While `inhibit` is 1, `ras`, `cas_hi`, `cas_lo`, `we` and `dack` are 0, and no cycle starts.
- R11: `we` is 1 only while a column strobe is active and `write` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 23 | CPU word address bits 23:1 |
| uds | input | 1 | Upper byte strobe, active high |
| lds | input | 1 | Lower byte strobe, active high |
| write | input | 1 | 1 = write, 0 = read |
| addr_strobe | input | 1 | CPU access in progress, active high |
| inhibit | input | 1 | Startup inhibit: blocks all strobes |
| mod_size | input | 2 | 0 = 64K, 1 = 256K, 2 or 3 = 1M modules |
| two_rows | input | 1 | Second module row fitted |
| dram_addr | output | 10 | Multiplexed DRAM address |
| ras | output | 1 | Row strobe, shared by both rows |
| cas_hi | output | 2 | High-byte column strobe per module row |
| cas_lo | output | 2 | Low-byte column strobe per module row |
| we | output | 1 | DRAM write enable |
| dack | output | 1 | Data acknowledge to the CPU |

## Verification
The bench chooses addresses that light up a single multiplexer slot at a time. If slot 7 or slot 9 took the wrong source for a strap setting, the row or column word would differ from the expected value.

The bench also checks the module-row choice under every size, and the folding onto row 0 when only one row is fitted. A wrong select bit, or a leak onto row 1, shows up as a strobe on the wrong bit of `cas_hi` or `cas_lo`.

Three timing cases are covered: an access reissued back to back, to confirm the row strobe stays low for exactly the precharge time; inhibit held at the start of an access; and inhibit raised in the middle of an access. A design that handled these wrongly would start the row strobe early, or would strobe while inhibited.

// File: rtl/dram_mux_seq.sv
module dram_mux_seq #(
  parameter int PRECHARGE_CLKS = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [23:1] addr,
  input  logic        uds,
  input  logic        lds,
  input  logic        write,
  input  logic        addr_strobe,
  input  logic        inhibit,
  input  logic [1:0]  mod_size,
  input  logic        two_rows,
  output logic [9:0]  dram_addr,
  output logic        ras,
  output logic [1:0]  cas_hi,
  output logic [1:0]  cas_lo,
  output logic        we,
  output logic        dack
);
  localparam int CW = (PRECHARGE_CLKS > 1) ? $clog2(PRECHARGE_CLKS) : 1;
  localparam logic [CW-1:0] PRE_LAST = CW'(PRECHARGE_CLKS - 1);

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_COL, S_STRB, S_ACK, S_PRE} st_t;
  st_t st;
  logic [CW-1:0] pcnt;

  wire start = addr_strobe && !inhibit;
  wire quit  = !addr_strobe || inhibit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      pcnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) st <= S_ROW;
        S_ROW:  st <= quit ? S_PRE : S_COL;
        S_COL:  st <= quit ? S_PRE : S_STRB;
        S_STRB: st <= quit ? S_PRE : S_ACK;
        S_ACK:  if (quit) st <= S_PRE;
        S_PRE: begin
          if (pcnt == PRE_LAST) begin
            pcnt <= '0;
            st   <= start ? S_ROW : S_IDLE;
          end else begin
            pcnt <= pcnt + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  wire is_64k = (mod_size == 2'd0);
  wire is_1m  = mod_size[1];
  wire x7_row = is_64k ? addr[10] : addr[17];
  wire x9_row = is_1m & addr[20];
  wire x9_col = is_1m & addr[19];
  wire bank   = two_rows & (is_64k ? addr[17] : (is_1m ? addr[21] : addr[19]));

  wire [9:0] row_word = {x9_row, addr[18], x7_row, addr[16:11], addr[1]};
  wire [9:0] col_word = {x9_col, addr[10], addr[9], addr[8:2]};
  wire col_phase = (st == S_COL) || (st == S_STRB) || (st == S_ACK);
  wire cas_on    = ((st == S_STRB) || (st == S_ACK)) && !inhibit;

  assign dram_addr = col_phase ? col_word : row_word;
  assign ras       = (col_phase || st == S_ROW) && !inhibit;
  assign cas_hi    = {cas_on & uds & bank, cas_on & uds & ~bank};
  assign cas_lo    = {cas_on & lds & bank, cas_on & lds & ~bank};
  assign we        = cas_on & write;
  assign dack      = (st == S_ACK) && !inhibit;
endmodule

// File: rtl/dram_mux_seq_chk.sv
module dram_mux_seq_chk #(
  parameter int PRECHARGE_CLKS = 2
) (
  input logic       clk,
  input logic       rst_n,
  input logic       uds,
  input logic       lds,
  input logic       write,
  input logic       inhibit,
  input logic       two_rows,
  input logic       ras,
  input logic [1:0] cas_hi,
  input logic [1:0] cas_lo,
  input logic       we,
  input logic       dack
);
  wire any_cas = |{cas_hi, cas_lo};
  logic [7:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gap <= 8'hff;
    else if (ras) gap <= '0;
    else if (gap != 8'hff) gap <= gap + 1'b1;
  end

  AST_CAS_NEEDS_RAS: assert property (@(posedge clk) disable iff (!rst_n) any_cas |-> ras); // R4
  AST_ROW1_ABSENT: assert property (@(posedge clk) disable iff (!rst_n) !two_rows |-> (!cas_hi[1] && !cas_lo[1])); // R6
  AST_ONE_ROW_ONLY: assert property (@(posedge clk) disable iff (!rst_n) !(|cas_hi[1] | |cas_lo[1]) || !(cas_hi[0] | cas_lo[0])); // R5
  AST_BYTE_GATE: assert property (@(posedge clk) disable iff (!rst_n) ((|cas_hi) |-> uds) and ((|cas_lo) |-> lds)); // R7
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n) $rose(ras) |-> (gap >= 8'(PRECHARGE_CLKS))); // R9
  AST_INHIBIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n) inhibit |-> !(ras || any_cas || we || dack)); // R10
  AST_WE_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n) we |-> (any_cas && write)); // R11
  AST_DACK_IN_CAS: assert property (@(posedge clk) disable iff (!rst_n) dack |-> any_cas || !(uds || lds)); // R8
endmodule

bind dram_mux_seq dram_mux_seq_chk #(.PRECHARGE_CLKS(PRECHARGE_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .uds(uds), .lds(lds), .write(write),
  .inhibit(inhibit), .two_rows(two_rows), .ras(ras), .cas_hi(cas_hi),
  .cas_lo(cas_lo), .we(we), .dack(dack)
);

// File: tb/tb_dram_mux_seq.sv
module tb_dram_mux_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] baddr = '0;
  logic        uds = 1'b0, lds = 1'b0, write = 1'b0, addr_strobe = 1'b0, inhibit = 1'b0;
  logic [1:0]  mod_size = '0;
  logic        two_rows = 1'b0;
  logic [9:0]  dram_addr;
  logic        ras, we, dack;
  logic [1:0]  cas_hi, cas_lo;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  dram_mux_seq dut (
    .clk(clk), .rst_n(rst_n), .addr(baddr[23:1]), .uds(uds), .lds(lds),
    .write(write), .addr_strobe(addr_strobe), .inhibit(inhibit),
    .mod_size(mod_size), .two_rows(two_rows), .dram_addr(dram_addr),
    .ras(ras), .cas_hi(cas_hi), .cas_lo(cas_lo), .we(we), .dack(dack)
  );

  typedef struct packed {
    logic [1:0]  sz;
    logic        two;
    logic        u;
    logic        l;
    logic        w;
    logic [23:0] a;
    logic [9:0]  row;
    logic [9:0]  col;
    logic [1:0]  hi;
    logic [1:0]  lo;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 24'h000002, 10'h001, 10'h000, 2'b01, 2'b01},
    '{2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 24'h020400, 10'h080, 10'h100, 2'b10, 2'b00},
    '{2'd1, 1'b1, 1'b0, 1'b1, 1'b0, 24'h0A0200, 10'h080, 10'h080, 2'b00, 2'b10},
    '{2'd2, 1'b1, 1'b1, 1'b1, 1'b1, 24'h3C0000, 10'h300, 10'h200, 2'b10, 2'b10},
    '{2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 24'h3C0000, 10'h300, 10'h200, 2'b01, 2'b01},
    '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 24'h0001FC, 10'h000, 10'h07F, 2'b01, 2'b01},
    '{2'd0, 1'b1, 1'b1, 1'b1, 1'b0, 24'h01F800, 10'h07E, 10'h000, 2'b01, 2'b01},
    '{2'd1, 1'b1, 1'b1, 1'b1, 1'b0, 24'h100000, 10'h000, 10'h000, 2'b01, 2'b01},
    '{2'd2, 1'b1, 1'b0, 1'b1, 1'b1, 24'h100000, 10'h200, 10'h000, 2'b00, 2'b01}
  };

  task automatic cmp(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_check(input string req);
    cmp(req, {ras, cas_hi, cas_lo, we, dack}, 32'h0);
  endtask

  task automatic run_vec(input vec_t v);
    baddr = v.a; uds = v.u; lds = v.l; write = v.w;
    mod_size = v.sz; two_rows = v.two; addr_strobe = 1'b1;
    @(negedge clk);
    cmp("R2 ras", ras, 1); cmp("R2 row addr", dram_addr, v.row);
    cmp("R4 cas early", {cas_hi, cas_lo}, 0);
    @(negedge clk);
    cmp("R3 col addr", dram_addr, v.col); cmp("R4 cas early", {cas_hi, cas_lo}, 0);
    @(negedge clk);
    cmp("R5 R6 R7 cas_hi", cas_hi, v.hi); cmp("R5 R6 R7 cas_lo", cas_lo, v.lo);
    cmp("R11 we", we, v.w); cmp("R8 dack early", dack, 0); cmp("R3 col hold", dram_addr, v.col);
    @(negedge clk);
    cmp("R8 dack", dack, 1); cmp("R4 ras held", ras, 1);
    addr_strobe = 1'b0;
    @(negedge clk);
    idle_check("R8 release");
    @(negedge clk); @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    idle_check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    idle_check("R1 after reset");

    for (int i = 0; i < NV; i++) run_vec(VEC[i]);

    // R9: back-to-back access, row strobe low exactly PRECHARGE_CLKS clocks
    baddr = 24'h000002; uds = 1; lds = 1; write = 0; mod_size = 0; two_rows = 1;
    addr_strobe = 1;
    repeat (4) @(negedge clk);
    addr_strobe = 0;
    @(negedge clk);
    cmp("R9 precharge 1", ras, 0);
    addr_strobe = 1;
    @(negedge clk);
    cmp("R9 precharge 2", ras, 0);
    @(negedge clk);
    cmp("R9 restart", ras, 1); cmp("R2 restart addr", dram_addr, 10'h001);
    addr_strobe = 0;
    repeat (4) @(negedge clk);

    // R10: inhibit held at start
    inhibit = 1; addr_strobe = 1;
    repeat (3) begin
      @(negedge clk);
      idle_check("R10 inhibit start");
    end
    addr_strobe = 0; inhibit = 0;
    repeat (3) @(negedge clk);

    // R10: inhibit raised mid-access
    addr_strobe = 1; write = 1;
    repeat (3) @(negedge clk);
    cmp("R11 we mid", we, 1);
    inhibit = 1;
    #1;
    idle_check("R10 inhibit mid");
    @(negedge clk);
    idle_check("R10 inhibit after");
    addr_strobe = 0; inhibit = 0;
    repeat (3) @(negedge clk);
    idle_check("R8 idle end");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule